// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is one bank of general-purpose I/O pins with per-pin direction control, an output latch, a synchronized input view and an event detector that raises one interrupt line. Software reaches it through a word-wide register bus. Each register offset is one word, and each register holds one bit per pin. The output latch and the interrupt enables have no plain write port. They change only through a write-one-to-set alias and a write-one-to-clear alias, so two agents can update different pins without a read-modify-write race.

Each pin can be armed for rising edges, falling edges, low level and high level. The four enables are independent and can be combined on one pin. An armed event on a pin whose interrupt enable is 1 latches a sticky status bit. The interrupt line is high while any status bit is set. When a detect-enable register is written, detection is held off for a fixed number of cycles so that the synchronizer and the edge pipeline can flush stale samples first.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input), and the output latch, the four detect enables, the interrupt enables, the status register and `irq` are all zero.
- R2: The direction register is at offset 0. A 1 makes the pin an input (`pad_oe` bit 0) and a 0 makes it a driven output (`pad_oe` bit 1). `pad_out` always shows the output latch.
- R3: A write of a mask to offset 2 sets the masked bits of the output latch and leaves every other bit unchanged. Offsets 1, 2 and 3 all read back the latch.
- R4: A write of a mask to offset 3 clears the masked bits of the output latch and leaves every other bit unchanged.
- R5: Offset 4 reads the input pins through a two-flop synchronizer. A pin change applied before a clock edge is visible after the second edge and not after the first.
- R6: Offset 5 enables rising-edge detection and offset 6 enables falling-edge detection. With both enabled, a pin reports each edge in either direction. An edge whose type is not enabled reports nothing.
- R7: Offset 7 enables low-level detection and offset 8 enables high-level detection. A pin armed for both reports in either level.
- R8: Writing ones to offset 9 enables the interrupts of those pins. Writing ones to offset 10 disables them. Both offsets read back the enable register. A status bit is set only while its pin's interrupt enable is 1, and an event seen while the pin is disabled is not stored.
- R9: The status register is at offset 11. Writing ones clears those bits, and a bit whose event is still present in the same cycle stays set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: After a write to any of offsets 5 to 8, no status bit is set for 5 clock edges. The sixth edge after the write edge is the first that can set a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | NPINS | Write data or bit mask |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| pad_in | input | NPINS | Pin levels (asynchronous) |
| pad_out | output | NPINS | Output latch value |
| pad_oe | output | NPINS | Per-pin output drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before the first access. They also assume that every write uses a single-cycle strobe, so the `$past` of the write data in each consequent is the mask that was applied. The bench keeps within this: it changes `pad_in` and the bus signals only at falling edges, asserts each write for exactly one rising edge, and lets the pins settle for several cycles between patterns. Edge events therefore never overlap the 5-cycle hold-off unless a test is aimed at that window.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int ADDR_W = 4;

    // Word offsets of the bank registers
    localparam logic [ADDR_W-1:0] OFS_DIR      = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_DOUT     = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_DIN      = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_RISE     = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_FALL     = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_LOW      = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_HIGH     = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_IEN_SET  = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_IEN_CLR  = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 4'd11;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
// Input synchronizer chain plus one history stage for edge comparison.
module gpio_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pad_in;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign cur  = chain_q[STAGES-1];
    assign prev = chain_q[STAGES];

    // R5: the history stage is the synchronized value one cycle later
    a_r5_history: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prev == $past(cur));
endmodule

// File: rtl/gpio_bank_detect.sv
`timescale 1ns/1ps
// Per-pin event detection with a hold-off window after detect-enable writes.
module gpio_bank_detect #(
    parameter int W          = 32,
    parameter int SETTLE_CYC = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    input  logic [W-1:0] en_low,
    input  logic [W-1:0] en_high,
    input  logic         cfg_wr,
    output logic [W-1:0] evt,
    output logic         block
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [W-1:0]     rise, fall;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        evt  = (rise & en_rise) | (fall & en_fall) |
               (~cur & en_low)  | (cur & en_high);
        if (cfg_wr) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign block = (cnt_q != '0);

    a_r11_holdoff_starts: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> block);
    a_r11_holdoff_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (block && !cfg_wr) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/gpio_bank_status.sv
`timescale 1ns/1ps
// Sticky event status, write-one-to-clear, set wins over clear.
module gpio_bank_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] ien,
    input  logic         block,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] st_d, st_q;
    logic [W-1:0] set_mask;

    always_comb begin
        set_mask = block ? '0 : (evt & ien);
        st_d     = (st_q & ~clr) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;
    assign irq    = |st_q;

    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q & ~$past(st_q) & ~$past(ien)) == '0);
    a_r11_no_set_in_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (st_q & ~$past(st_q)) == '0);
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> (st_q & $past(clr) & ~$past(evt & ien)) == '0);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!block && ((evt & ien) != '0)) |=> (st_q & $past(evt & ien)) == $past(evt & ien));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] en_rise;
        logic [NPINS-1:0] en_fall;
        logic [NPINS-1:0] en_low;
        logic [NPINS-1:0] en_high;
        logic [NPINS-1:0] ien;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             wr;
    logic             cfg_wr;
    logic [NPINS-1:0] status_clr;
    logic [NPINS-1:0] sync_cur, sync_prev;
    logic [NPINS-1:0] evt;
    logic             block;
    logic [NPINS-1:0] status;

    assign wr = bus_sel & bus_we;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_wr     = 1'b0;
        status_clr = '0;
        if (wr) begin
            case (bus_addr)
                OFS_DIR:      cfg_d.dir  = bus_wdata;
                OFS_DOUT_SET: cfg_d.dout = cfg_q.dout | bus_wdata;
                OFS_DOUT_CLR: cfg_d.dout = cfg_q.dout & ~bus_wdata;
                OFS_RISE: begin
                    cfg_d.en_rise = bus_wdata;
                    cfg_wr        = 1'b1;
                end
                OFS_FALL: begin
                    cfg_d.en_fall = bus_wdata;
                    cfg_wr        = 1'b1;
                end
                OFS_LOW: begin
                    cfg_d.en_low = bus_wdata;
                    cfg_wr       = 1'b1;
                end
                OFS_HIGH: begin
                    cfg_d.en_high = bus_wdata;
                    cfg_wr        = 1'b1;
                end
                OFS_IEN_SET:  cfg_d.ien  = cfg_q.ien | bus_wdata;
                OFS_IEN_CLR:  cfg_d.ien  = cfg_q.ien & ~bus_wdata;
                OFS_STATUS:   status_clr = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.dir <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DIR:      bus_rdata = cfg_q.dir;
            OFS_DOUT,
            OFS_DOUT_SET,
            OFS_DOUT_CLR: bus_rdata = cfg_q.dout;
            OFS_DIN:      bus_rdata = sync_cur;
            OFS_RISE:     bus_rdata = cfg_q.en_rise;
            OFS_FALL:     bus_rdata = cfg_q.en_fall;
            OFS_LOW:      bus_rdata = cfg_q.en_low;
            OFS_HIGH:     bus_rdata = cfg_q.en_high;
            OFS_IEN_SET,
            OFS_IEN_CLR:  bus_rdata = cfg_q.ien;
            OFS_STATUS:   bus_rdata = status;
            default:      bus_rdata = '0;
        endcase
    end

    assign pad_out = cfg_q.dout;
    assign pad_oe  = ~cfg_q.dir;

    gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .cur    (sync_cur),
        .prev   (sync_prev)
    );

    gpio_bank_detect #(.W(NPINS), .SETTLE_CYC(SETTLE_CYC)) i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (sync_cur),
        .prev    (sync_prev),
        .en_rise (cfg_q.en_rise),
        .en_fall (cfg_q.en_fall),
        .en_low  (cfg_q.en_low),
        .en_high (cfg_q.en_high),
        .cfg_wr  (cfg_wr),
        .evt     (evt),
        .block   (block)
    );

    gpio_bank_status #(.W(NPINS)) i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .ien    (cfg_q.ien),
        .block  (block),
        .clr    (status_clr),
        .status (status),
        .irq    (irq)
    );

    a_r3_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_DOUT_SET) |=>
            ((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));
    a_r4_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_DOUT_CLR) |=>
            ((pad_out & $past(bus_wdata)) == '0) &&
            ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));
    a_r8_ien_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_IEN_SET) |=> (cfg_q.ien & $past(bus_wdata)) == $past(bus_wdata));
    a_r2_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> $stable(pad_out) && $stable(pad_oe));
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] model;
        logic [31:0] pins;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(4'd0, r);  chk("R1 dir", r, 32'hFFFF_FFFF);
        rd(4'd1, r);  chk("R1 dout", r, 32'h0);
        rd(4'd5, r);  chk("R1 rise", r, 32'h0);
        rd(4'd8, r);  chk("R1 high", r, 32'h0);
        rd(4'd9, r);  chk("R1 ien", r, 32'h0);
        rd(4'd11, r); chk("R1 status", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 oe", pad_oe, 32'h0);

        // R2 direction
        wr(4'd0, 32'hFFFF_0000);
        chk("R2 oe", pad_oe, 32'h0000_FFFF);
        wr(4'd0, 32'h0F0F_F0F0);
        chk("R2 oe", pad_oe, 32'hF0F0_0F0F);

        // R3 R4 set/clear sweep against a model
        model = '0;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] m;
            m = (32'h1 << k) | (32'(k) * 32'h9E37_79B9);
            if (k % 3 == 2) begin
                wr(4'd3, m); model = model & ~m;
                chk("R4 clr", pad_out, model);
            end else begin
                wr(4'd2, m); model = model | m;
                chk("R3 set", pad_out, model);
            end
            rd(4'd1, r); chk("R3 readback", r, model);
        end
        wr(4'd3, 32'hFFFF_FFFF);
        chk("R4 clear all", pad_out, 32'h0);

        // R5 synchronizer latency, one pin at a time
        for (int p = 0; p < 32; p++) begin
            logic [31:0] old;
            old = (p == 0) ? 32'h0 : (32'h1 << (p - 1));
            pad_in = 32'h1 << p;
            cyc(1); rd(4'd4, r); chk("R5 one edge", r, old);
            cyc(1); rd(4'd4, r); chk("R5 two edges", r, 32'h1 << p);
            cyc(2);
        end
        pad_in = '0;
        cyc(4);

        // R6 rising edge sweep
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);
        cyc(10);
        pins = '0;
        for (int p = 0; p < 32; p++) begin
            pins = pins | (32'h1 << p);
            pad_in = pins;
            cyc(4);
            rd(4'd11, r); chk("R6 rise", r, 32'h1 << p);
            chk("R10 irq high", {31'b0, irq}, 32'h1);
            wr(4'd11, 32'h1 << p);
            rd(4'd11, r); chk("R9 w1c", r, 32'h0);
            chk("R10 irq low", {31'b0, irq}, 32'h0);
        end
        pad_in = '0;
        cyc(4);
        rd(4'd11, r); chk("R6 fall not armed", r, 32'h0);

        // R6 falling only on a nibble
        wr(4'd5, 32'h0);
        wr(4'd6, 32'h0000_00F0);
        cyc(10);
        pad_in = 32'h0000_00FF; cyc(4);
        rd(4'd11, r); chk("R6 rise not armed", r, 32'h0);
        pad_in = 32'h0; cyc(4);
        rd(4'd11, r); chk("R6 fall", r, 32'h0000_00F0);
        wr(4'd11, 32'hFFFF_FFFF);

        // R6 both edges on pin 0
        wr(4'd5, 32'h1);
        wr(4'd6, 32'h1);
        cyc(10);
        wr(4'd11, 32'hFFFF_FFFF);
        pad_in = 32'h1; cyc(4);
        rd(4'd11, r); chk("R6 both rise", r, 32'h1);
        wr(4'd11, 32'h1);
        pad_in = 32'h0; cyc(4);
        rd(4'd11, r); chk("R6 both fall", r, 32'h1);
        wr(4'd11, 32'h1);

        // R8 interrupt enable gating
        wr(4'd10, 32'h1);
        rd(4'd9, r); chk("R8 ien clr", r, 32'hFFFF_FFFE);
        pad_in = 32'h1; cyc(4);
        rd(4'd11, r); chk("R8 gated", r, 32'h0);
        chk("R8 irq gated", {31'b0, irq}, 32'h0);
        wr(4'd9, 32'h1);
        cyc(3);
        rd(4'd11, r); chk("R8 not stored", r, 32'h0);
        rd(4'd10, r); chk("R8 ien set", r, 32'hFFFF_FFFF);

        // R7 levels
        wr(4'd5, 32'h0);
        wr(4'd6, 32'h0);
        pad_in = 32'h0;
        wr(4'd7, 32'h0000_0004);
        wr(4'd8, 32'h0000_0008);
        cyc(10);
        rd(4'd11, r); chk("R7 low level", r, 32'h4);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, r); chk("R9 set wins", r, 32'h4);
        pad_in = 32'h0000_000C; cyc(4);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, r); chk("R7 high level", r, 32'h8);
        wr(4'd7, 32'h10);
        wr(4'd8, 32'h10);
        cyc(10);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, r); chk("R7 both low", r, 32'h10);
        pad_in = 32'h10; cyc(4);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, r); chk("R7 both high", r, 32'h10);
        wr(4'd7, 32'h0);
        wr(4'd8, 32'h0);
        cyc(10);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, r); chk("R7 disarmed", r, 32'h0);
        chk("R10 idle", {31'b0, irq}, 32'h0);

        // R11 hold-off window
        pad_in = 32'h40; cyc(6);
        wr(4'd8, 32'h40);
        cyc(5);
        rd(4'd11, r); chk("R11 held off", r, 32'h0);
        chk("R11 irq held", {31'b0, irq}, 32'h0);
        cyc(1);
        rd(4'd11, r); chk("R11 first edge", r, 32'h40);
        chk("R10 irq level", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule